// File: doc/BRIEF.md
# Serial Boost Configuration Register Chain

This block supplies the 5-bit boost level for each of four equalizer channels. A level comes from one of two sources. The first is a strap code on per-channel ternary control inputs. The second is a 21-bit serial shift chain that a host loads one bit per clock. The chain's output repeats its input 21 bits later, so several blocks can be connected in series on one serial line and loaded with one long stream.

One bit of the chain is a source flag. The other twenty bits hold one 5-bit boost word per channel. The chain only shifts while an active-low enable is held low. Its contents reach the outputs only when the enable is released, so a frame that is half shifted never disturbs the equalizers.

A program-mode input that is held low clears the whole chain and returns every channel to strap control. The serial clock is the block's only clock.

Top module: `boost_cfg_chain`

## Requirements
- R1: While `rdy` (R9) holds and `en_n` is low, each rising edge of `clk` shifts the 21-bit chain. `sdi` enters register 1, every bit moves up by one register, and `sdo` shows register 21. A bit sampled at one edge therefore appears on `sdo` after the 20th following edge, which puts `sdo` 21 bits behind `sdi`.
- R2: While `en_n` is high, the chain contents and `sdo` hold at every edge, whatever `sdi` does.
- R3: The last bit shifted in sits in register 1, which is the source flag. Channel c (c = 0..3, output bits `boost_lvl[5c+4:5c]`) takes its word from registers 5c+2 through 5c+6, with the lowest-numbered register as the MSB.
- R4: A commit happens at the first rising edge at which `en_n` is high after having been low at the previous edge. At a commit the flag and the four words are captured for use. Between commits, shifting and strap changes leave `boost_lvl` unchanged while the captured flag is 1.
- R5: While the captured flag is 0, each channel's `boost_lvl` follows that channel's decoded strap code without a clock.
- R6: Channel c's strap is `pin_trits[6c+5:6c]`. Digit A is bits [6c+5:6c+4] and is the most significant, then B, then C. The digit codes are 00 = 0, 01 = 1, 10 = 2, and 11 is read as 0. The value is v = 9A + 3B + C.
- R7: The strap value v maps to the level floor((31·v + 13) / 26). This gives 0 for v = 0, 16 for v = 13 and 31 for v = 26.
- R8: While `prog_mode` is low, the chain and the captured state are cleared at once without waiting for a clock. `sdo` is 0 and every channel is under strap control. This is also the power-up state.
- R9: After `prog_mode` rises, the first two rising edges of `clk` are ignored and keep the chain clear. The third edge is the first one that can shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, the only clock |
| prog_mode | input | 1 | High enables serial loading; low clears and forces strap control |
| en_n | input | 1 | Active-low shift enable; its release commits the chain |
| sdi | input | 1 | Serial data in |
| pin_trits | input | 24 | Four channels of three 2-bit ternary digit codes |
| sdo | output | 1 | Serial data out, from register 21 |
| boost_lvl | output | 20 | Four 5-bit boost levels, channel 0 in the low bits |

## Verification
The hardest situation to reach is the release of `prog_mode`, where two edges are deliberately lost. The stimulus holds the enable low with a 1 on `sdi` before `prog_mode` rises and keeps shifting for 21 edges. A captured first bit would then surface on `sdo`, so a mistake in the release logic shows up at the serial output. The commit edge is tested by stopping a frame partway through and by changing the straps while the flag is set. A second `prog_mode` drop between clock edges checks that the clear does not wait for a clock.

// File: rtl/boost_cfg_chain.sv
module boost_cfg_chain #(
  parameter int CHANNELS = 4,
  parameter int WORD_W   = 5,
  parameter int DIGITS   = 3
) (
  input  logic                         clk,
  input  logic                         prog_mode,
  input  logic                         en_n,
  input  logic                         sdi,
  input  logic [CHANNELS*DIGITS*2-1:0] pin_trits,
  output logic                         sdo,
  output logic [CHANNELS*WORD_W-1:0]   boost_lvl
);

  localparam int TRIT_W    = 2;
  localparam int CHAIN_LEN = 1 + CHANNELS * WORD_W;
  localparam int MAX_CODE  = 3 ** DIGITS - 1;
  localparam int MAX_LVL   = 2 ** WORD_W - 1;
  localparam int STRAP_W   = DIGITS * TRIT_W;

  function automatic logic [WORD_W-1:0] strap_level(input logic [STRAP_W-1:0] t);
    int v;
    logic [TRIT_W-1:0] code;
    v = 0;
    for (int d = DIGITS - 1; d >= 0; d--) begin
      code = t[d*TRIT_W +: TRIT_W];
      v = v * 3 + ((code == 2'b11) ? 0 : int'(code));
    end
    return WORD_W'((v * MAX_LVL + MAX_CODE / 2) / MAX_CODE);
  endfunction

  logic [1:0]                  rel;
  logic                        rdy;
  logic [CHAIN_LEN-1:0]        chain;
  logic                        en_q;
  logic                        act_sel;
  logic                        commit;
  logic [CHANNELS*WORD_W-1:0]  chain_words;
  logic [CHANNELS*WORD_W-1:0]  word_q;
  logic [CHANNELS*WORD_W-1:0]  pin_lvl;

  always_ff @(posedge clk or negedge prog_mode)
    if (!prog_mode) rel <= '0;
    else            rel <= {rel[0], 1'b1};

  assign rdy = rel[1];

  always_ff @(posedge clk or negedge prog_mode)
    if (!prog_mode)   chain <= '0;
    else if (!rdy)    chain <= '0;
    else if (!en_n)   chain <= {chain[CHAIN_LEN-2:0], sdi};

  assign sdo    = chain[CHAIN_LEN-1];
  assign commit = rdy & en_n & ~en_q;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
      assign chain_words[c*WORD_W + (WORD_W-1-j)] = chain[1 + c*WORD_W + j];
    end
    assign pin_lvl[c*WORD_W +: WORD_W] = strap_level(pin_trits[c*STRAP_W +: STRAP_W]);
  end

  always_ff @(posedge clk or negedge prog_mode)
    if (!prog_mode) begin
      en_q    <= 1'b1;
      act_sel <= 1'b0;
      word_q  <= '0;
    end else if (!rdy) begin
      en_q    <= 1'b1;
      act_sel <= 1'b0;
      word_q  <= '0;
    end else begin
      en_q <= en_n;
      if (commit) begin
        act_sel <= chain[0];
        word_q  <= chain_words;
      end
    end

  assign boost_lvl = act_sel ? word_q : pin_lvl;

  // R2
  hold_sdo_chk: assert property (@(posedge clk) disable iff (!prog_mode)
    (rdy && en_n) |=> $stable(sdo));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!prog_mode)
    (!rdy) |=> (sdo == 1'b0 && !act_sel));

  // R4
  reg_mode_hold_chk: assert property (@(posedge clk) disable iff (!prog_mode)
    (rdy && !commit && act_sel) |=> $stable(boost_lvl));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!prog_mode)
    (rdy && !commit) |=> $stable(word_q));

endmodule

// File: tb/test_boost_cfg_chain.sv
module test_boost_cfg_chain;

  logic        clk = 1'b0;
  logic        prog_mode = 1'b0;
  logic        en_n = 1'b1;
  logic        sdi = 1'b0;
  logic [23:0] pins = '0;
  wire         sdo;
  wire  [19:0] boost;

  boost_cfg_chain i_boost_cfg_chain (
    .clk(clk), .prog_mode(prog_mode), .en_n(en_n), .sdi(sdi),
    .pin_trits(pins), .sdo(sdo), .boost_lvl(boost)
  );

  always #2 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  bit  run_cmp = 0;

  bit        mq[$];
  int        msync;
  bit        mact;
  bit        mprev;
  bit [19:0] mwords;
  bit        mcommit;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  function automatic int lvl_of(input logic [5:0] t);
    int v = 0;
    for (int d = 2; d >= 0; d--) begin
      int code = int'(t[d*2 +: 2]);
      v = v * 3 + ((code == 3) ? 0 : code);
    end
    return (31 * v + 13) / 26;
  endfunction

  function automatic logic [19:0] pin_exp(input logic [23:0] p);
    logic [19:0] r;
    for (int c = 0; c < 4; c++) r[c*5 +: 5] = 5'(lvl_of(p[c*6 +: 6]));
    return r;
  endfunction

  function automatic logic [5:0] trits_of(input int v);
    return {2'(v / 9), 2'((v / 3) % 3), 2'(v % 3)};
  endfunction

  function automatic bit [19:0] words_of();
    bit [19:0] w;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 5; j++) w[c*5 + 4 - j] = mq[1 + c*5 + j];
    return w;
  endfunction

  function automatic bit [20:0] make_frame(input bit flag, input bit [19:0] w);
    bit [20:0] f;
    f[0] = flag;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 5; j++) f[1 + c*5 + j] = w[c*5 + 4 - j];
    return f;
  endfunction

  task automatic model_clear();
    mq.delete();
    repeat (21) mq.push_back(1'b0);
    mact = 0; mprev = 1; mwords = '0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge prog_mode) begin
    if (!prog_mode) begin
      model_clear(); msync = 0;
    end else if (msync < 2) begin
      msync++; model_clear();
    end else begin
      mcommit = en_n && !mprev;
      if (!en_n) begin
        mq.push_front(sdi);
        void'(mq.pop_back());
      end
      if (mcommit) begin
        mact = mq[0];
        mwords = words_of();
      end
      mprev = en_n;
    end
  end

  function automatic logic [19:0] model_boost();
    return mact ? logic'(1'b1) ? mwords : '0 : pin_exp(pins);
  endfunction

  always @(negedge clk) if (run_cmp) begin
    chk(sdo === mq[20], "R1 model sdo", sdo, mq[20]);
    chk(boost === model_boost(), "R5 model boost", boost, model_boost());
  end

  task automatic sh(input bit e, input bit d);
    #1 en_n = e; sdi = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    bit [20:0] fr;
    bit [19:0] w;
    bit        sent[$];
    logic [19:0] hold;
    logic        sdo_hold;

    @(negedge clk); @(negedge clk);
    // R8 power-up / mode low
    chk(sdo === 1'b0, "R8 reset sdo", sdo, 0);
    chk(boost === 20'h0, "R8 reset boost", boost, 0);
    run_cmp = 1;

    // R6 R7 strap sweep
    for (int v = 0; v < 27; v++) begin
      #1;
      for (int c = 0; c < 4; c++) pins[c*6 +: 6] = trits_of((v + 7*c) % 27);
      #1;
      for (int c = 0; c < 4; c++)
        chk(boost[c*5 +: 5] === 5'((31 * ((v + 7*c) % 27) + 13) / 26), "R7 sweep",
            boost[c*5 +: 5], (31 * ((v + 7*c) % 27) + 13) / 26);
      @(negedge clk);
    end
    #1 pins = {trits_of(26), trits_of(13), trits_of(0), 6'b111111};
    #1;
    chk(boost[19:15] === 5'd31, "R7 v26", boost[19:15], 31);
    chk(boost[14:10] === 5'd16, "R7 v13", boost[14:10], 16);
    chk(boost[9:5]   === 5'd0,  "R7 v0",  boost[9:5], 0);
    chk(boost[4:0]   === 5'd0,  "R6 code11", boost[4:0], 0);
    #1 pins[5:0] = 6'b110110;
    #1;
    chk(boost[4:0] === 5'd6, "R6 A11 B01 C10", boost[4:0], 6);
    @(negedge clk);

    // R9 release: enable low with a 1 before mode rises
    #1 en_n = 0; sdi = 1; prog_mode = 1;
    @(negedge clk);
    sh(0, 1);
    repeat (19) sh(0, 0);
    chk(sdo === 1'b0, "R9 first edges ignored", sdo, 0);
    sh(1, 0);
    sh(1, 0);

    // R3 R4 program a frame
    pins = {trits_of(5), trits_of(20), trits_of(9), trits_of(17)};
    w  = {5'h01, 5'h0A, 5'h1F, 5'h13};
    fr = make_frame(1'b1, w);
    for (int i = 20; i >= 0; i--) begin
      sh(0, fr[i]);
      if (i == 10) chk(boost === pin_exp(pins), "R4 partial frame hidden", boost, pin_exp(pins));
    end
    chk(boost === pin_exp(pins), "R4 before commit", boost, pin_exp(pins));
    sh(1, 0);
    for (int c = 0; c < 4; c++)
      chk(boost[c*5 +: 5] === w[c*5 +: 5], "R3 word placement", boost[c*5 +: 5], w[c*5 +: 5]);

    // R2 enable high holds
    sdo_hold = sdo; hold = boost;
    for (int i = 0; i < 6; i++) begin
      sh(1, i[0]);
      chk(sdo === sdo_hold, "R2 sdo held", sdo, sdo_hold);
    end
    #1 pins = ~pins;
    #1 chk(boost === hold, "R4 straps ignored under register control", boost, hold);
    @(negedge clk);

    // R1 daisy pass-through
    for (int i = 0; i < 42; i++) begin
      bit b = bit'((i * 5 + i / 3) % 2);
      if (i == 41) b = 0;
      sent.push_back(b);
      sh(0, b);
      if (i >= 20) chk(sdo === sent[i-20], "R1 delay 21", sdo, sent[i-20]);
    end
    sh(1, 0);
    chk(boost === pin_exp(pins), "R5 flag0 strap control", boost, pin_exp(pins));
    #1 pins = {trits_of(26), trits_of(1), trits_of(14), trits_of(22)};
    #1 chk(boost === pin_exp(pins), "R5 follows straps", boost, pin_exp(pins));
    @(negedge clk);

    // R8 async clear mid-cycle
    fr = make_frame(1'b1, 20'hABCDE);
    for (int i = 20; i >= 0; i--) sh(0, fr[i]);
    sh(1, 0);
    chk(boost === 20'hABCDE, "R3 second frame", boost, 20'hABCDE);
    #1 prog_mode = 0;
    #0.5;
    chk(sdo === 1'b0, "R8 async sdo", sdo, 0);
    chk(boost === pin_exp(pins), "R8 async strap", boost, pin_exp(pins));
    @(negedge clk);
    @(negedge clk);

    done = 1;
    finish_run();
  end

endmodule